// File: doc/BRIEF.md
# Time-Shared Neuron Engine

This block evaluates one neuron of a feed-forward perceptron network. A full set of signed fixed-point inputs arrives at once over a valid/ack handshake. The block multiplies each input by its locally stored weight, adds the products into one sum and passes that sum through a piecewise-linear sigmoid. The activated value is then presented to the next layer under a valid strobe that holds until the consumer takes it.

The datapath has exactly one 4-stage pipelined multiplier and one 4-stage pipelined adder. A fixed schedule issues one product per cycle. It pairs products into the two adder operands and feeds partial sums back into the same adder until one sum remains. The same two units then compute the activation: one multiply for the slope, one add for the segment offset, and one add that mirrors the result for negative arguments. Every step of the schedule runs whatever the data, so the latency from acceptance to result does not depend on the values.

The input count N is a design-time parameter, either 4 or 6. Data is Q8.8 two's complement, so 1.0 is 256.

Top module: `mlp_neuron_unit`

## Requirements
- R1: After reset `out_valid` and `in_ack` are 0 and every stored weight is 0. A set computed with no weights written therefore yields 128 (0.5).
- R2: A cycle with `wt_we` high writes `wt_val` into weight slot `wt_sel` at the clock edge. Input k pairs with slot k, and input k occupies bits [16k+15:16k] of `in_vec`.
- R3: The pre-activation sum s is the 16-bit wrapping sum, over all k, of bits [23:8] of the 32-bit signed product of input k and weight k.
- R4: For s ≥ 0, with m = s, the output is 256 when m ≥ 1280. It is (m·8)>>8 + 216 when 608 ≤ m < 1280, (m·32)>>8 + 160 when 256 ≤ m < 608, and (m·64)>>8 + 128 below 256. The output always lies in 0..256.
- R5: For s < 0 the output is 256 − y, where y is the R4 value for m = −s.
- R6: When |s| reaches the top segment, the output is 256 for positive s and 0 for negative s. This includes s = −32768, whose magnitude is taken as an unsigned 32768.
- R7: `in_ack` is high only in a cycle where `in_valid` is high and the block is idle with no result pending. It lasts one cycle, and `in_vec` is sampled in that cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` is stable and no new set is acknowledged. `out_valid` drops in the cycle after `out_ready` is seen.
- R9: `out_valid` first rises exactly 2·N+22 cycles after the acknowledge cycle: 34 for N = 6, and the same for every data pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_we | input | 1 | Weight write strobe |
| wt_sel | input | $clog2(N) | Weight slot to write |
| wt_val | input | 16 | Weight value, Q8.8 |
| in_valid | input | 1 | Input set offered by the previous layer |
| in_vec | input | 16·N | Input set, input k in bits [16k+15:16k] |
| in_ack | output | 1 | Input set taken this cycle |
| out_valid | output | 1 | Activated result available |
| out_ready | input | 1 | Next layer takes the result |
| out_data | output | 16 | Activated result, Q8.8 |

## Verification
The hardest cycle to reach is the one where the final product of a 6-input set reaches the adder in the same cycle as the first partial sum. The product must pair with its held partner while the sum waits in its own holding register. Any error there changes the sum in a way only certain value mixes expose. The vector table therefore uses sets in which every input and weight is non-zero and mixed in sign. A reference model recomputes each result from the stated arithmetic. Single-term sets pin the sum exactly onto segment edges, onto the saturation threshold and onto −32768.

// File: rtl/mlp_neuron_unit.sv
module mlp_neuron_unit #(
  parameter int N_IN = 6,
  parameter int DW   = 16,
  parameter int FRAC = 8,
  parameter int PIPE = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wt_we,
  input  logic [$clog2(N_IN)-1:0]     wt_sel,
  input  logic signed [DW-1:0]        wt_val,
  input  logic                        in_valid,
  input  logic [N_IN*DW-1:0]          in_vec,
  output logic                        in_ack,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic signed [DW-1:0]        out_data
);
  localparam int IW = $clog2(N_IN);
  localparam int CW = IW + 1;
  localparam logic signed [DW-1:0] ONE     = DW'(1 << FRAC);
  localparam logic signed [DW-1:0] SAT_T   = DW'(5 << FRAC);
  localparam logic signed [DW-1:0] MID_T   = DW'(19 << (FRAC-3));
  localparam logic signed [DW-1:0] OFS_HI  = DW'(27 << (FRAC-5));
  localparam logic signed [DW-1:0] OFS_MID = DW'(5 << (FRAC-3));
  localparam logic signed [DW-1:0] OFS_LO  = DW'(1 << (FRAC-1));
  localparam logic signed [DW-1:0] SLP_HI  = DW'(1 << (FRAC-5));
  localparam logic signed [DW-1:0] SLP_MID = DW'(1 << (FRAC-3));
  localparam logic signed [DW-1:0] SLP_LO  = DW'(1 << (FRAC-2));

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_ACC, S_SLOPE, S_OFS, S_INV, S_FIN, S_DONE} st_t;
  st_t st;

  logic signed [DW-1:0] wq [N_IN];
  logic signed [DW-1:0] xq [N_IN];
  logic [IW-1:0] cnt;
  logic [CW-1:0] nsum;
  logic signed [DW-1:0] mp [PIPE];
  logic signed [DW-1:0] ap [PIPE];
  logic [PIPE-1:0] mv, av;
  logic mul_iv, add_iv;
  logic signed [DW-1:0] mul_a, mul_b, add_a, add_b;
  logic signed [2*DW-1:0] mul_full;
  logic signed [DW-1:0] ph, sh, xs, ofs_q, res_q, mag, slp_c, ofs_c;
  logic ph_v, sh_v, neg_q;

  wire signed [DW-1:0] mul_o = mp[PIPE-1];
  wire signed [DW-1:0] add_o = ap[PIPE-1];
  wire mul_v = mv[PIPE-1];
  wire add_v = av[PIPE-1];
  wire accum    = (st == S_ISSUE) || (st == S_ACC);
  wire p_in     = accum && mul_v;
  wire last_sum = accum && add_v && (nsum == CW'(N_IN-2));
  wire s_in     = accum && add_v && !last_sum;
  wire pair_p   = p_in && ph_v;
  wire pair_s   = s_in && sh_v && !pair_p;
  wire mneg     = xs[DW-1];

  assign in_ack    = (st == S_IDLE) && in_valid;
  assign out_valid = (st == S_DONE);
  assign out_data  = res_q;
  assign mul_full  = mul_a * mul_b;
  assign mag       = mneg ? -xs : xs;

  always_comb begin
    if ($unsigned(mag) >= $unsigned(SAT_T))      begin slp_c = '0;      ofs_c = ONE;     end
    else if ($unsigned(mag) >= $unsigned(MID_T)) begin slp_c = SLP_HI;  ofs_c = OFS_HI;  end
    else if ($unsigned(mag) >= $unsigned(ONE))   begin slp_c = SLP_MID; ofs_c = OFS_MID; end
    else                                         begin slp_c = SLP_LO;  ofs_c = OFS_LO;  end
  end

  always_comb begin
    mul_iv = 1'b0; mul_a = '0; mul_b = '0;
    add_iv = 1'b0; add_a = '0; add_b = '0;
    if (pair_p) begin
      add_iv = 1'b1; add_a = ph; add_b = mul_o;
    end else if (pair_s) begin
      add_iv = 1'b1; add_a = sh; add_b = add_o;
    end
    case (st)
      S_ISSUE: begin mul_iv = 1'b1; mul_a = xq[cnt]; mul_b = wq[cnt]; end
      S_SLOPE: begin mul_iv = 1'b1; mul_a = mag; mul_b = slp_c; end
      S_OFS:   if (mul_v) begin add_iv = 1'b1; add_a = mul_o; add_b = ofs_q; end
      S_INV:   if (add_v) begin
                 add_iv = 1'b1;
                 add_a  = neg_q ? ONE : add_o;
                 add_b  = neg_q ? -add_o : '0;
               end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv <= '0; av <= '0;
      for (int i = 0; i < PIPE; i++) begin mp[i] <= '0; ap[i] <= '0; end
    end else begin
      mv[0] <= mul_iv; mp[0] <= mul_full[DW+FRAC-1:FRAC];
      av[0] <= add_iv; ap[0] <= add_a + add_b;
      for (int i = 1; i < PIPE; i++) begin
        mv[i] <= mv[i-1]; mp[i] <= mp[i-1];
        av[i] <= av[i-1]; ap[i] <= ap[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int k = 0; k < N_IN; k++) wq[k] <= '0;
    else if (wt_we && (int'(wt_sel) < N_IN)) wq[wt_sel] <= wt_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; nsum <= '0;
      ph <= '0; sh <= '0; ph_v <= 1'b0; sh_v <= 1'b0;
      xs <= '0; ofs_q <= '0; neg_q <= 1'b0; res_q <= '0;
      for (int k = 0; k < N_IN; k++) xq[k] <= '0;
    end else begin
      if (p_in) begin
        if (ph_v) ph_v <= 1'b0;
        else begin ph <= mul_o; ph_v <= 1'b1; end
      end
      if (s_in) begin
        if (pair_s) sh_v <= 1'b0;
        else if (!sh_v) begin sh <= add_o; sh_v <= 1'b1; end
      end
      if (accum && add_v) nsum <= nsum + 1'b1;
      case (st)
        S_IDLE: if (in_valid) begin
          for (int k = 0; k < N_IN; k++) xq[k] <= in_vec[k*DW +: DW];
          cnt <= '0; nsum <= '0; ph_v <= 1'b0; sh_v <= 1'b0;
          st <= S_ISSUE;
        end
        S_ISSUE: begin
          cnt <= cnt + 1'b1;
          if (cnt == IW'(N_IN-1)) st <= S_ACC;
        end
        S_ACC:   if (last_sum) begin xs <= add_o; st <= S_SLOPE; end
        S_SLOPE: begin neg_q <= mneg; ofs_q <= ofs_c; st <= S_OFS; end
        S_OFS:   if (mul_v) st <= S_INV;
        S_INV:   if (add_v) st <= S_FIN;
        S_FIN:   if (add_v) begin res_q <= add_o; st <= S_DONE; end
        S_DONE:  if (out_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mlp_neuron_unit_chk.sv
module mlp_neuron_unit_chk #(
  parameter int N_IN = 6,
  parameter int DW   = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ack,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_data
);
  localparam int EXP = 2*N_IN + 22;
  logic [7:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= '0;
    else if (in_ack) since <= 8'd1;
    else if (since != 8'd0 && since != 8'd255) since <= since + 8'd1;
  end

  // R7
  ack_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ack |-> in_valid);
  // R8
  no_ack_pending_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !in_ack);
  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
  // R4
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data >= 0 && out_data <= 256));
  // R9
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (since == 8'(EXP)));
endmodule

bind mlp_neuron_unit mlp_neuron_unit_chk #(.N_IN(N_IN), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ack(in_ack),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/mlp_neuron_unit_tb.sv
`timescale 1ns/1ps
module mlp_neuron_unit_tb;
  localparam int NI = 6;
  localparam int LAT = 2*NI + 22;
  localparam int NV = 5;
  localparam logic [NI*16-1:0] TX [NV] = '{
    96'h0100_0100_0100_0100_0100_0100,
    96'hFF80_0200_0040_FE00_0300_0080,
    96'h7F00_0001_8000_0010_1234_0A00,
    96'h0123_FEDC_0456_FBA9_0789_F876,
    96'hF000_0F00_00FF_FF01_0505_FAFA};
  localparam logic [NI*16-1:0] TW [NV] = '{
    96'h0040_0040_0040_0040_0040_0040,
    96'h0100_FF00_0080_0040_FFC0_0200,
    96'h0200_7FFF_0100_0100_0010_FF00,
    96'h1111_2222_3333_4444_5555_6666,
    96'h0010_0020_FFF0_0100_0008_0040};

  logic clk = 0, rst_n = 0;
  logic wt_we = 0;
  logic [2:0] wt_sel = '0;
  logic signed [15:0] wt_val = '0;
  logic in_valid = 0, out_ready = 0;
  logic [NI*16-1:0] in_vec = '0;
  logic in_ack, out_valid;
  logic signed [15:0] out_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mlp_neuron_unit #(.N_IN(NI)) u_dut (
    .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_sel(wt_sel), .wt_val(wt_val),
    .in_valid(in_valid), .in_vec(in_vec), .in_ack(in_ack),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic signed [15:0] ref_out(input logic [NI*16-1:0] xv, input logic [NI*16-1:0] wv);
    logic signed [15:0] s, xk, wk, a, y, sl, of;
    logic signed [31:0] f;
    bit neg;
    s = 0;
    for (int k = 0; k < NI; k++) begin
      xk = xv[k*16 +: 16];
      wk = wv[k*16 +: 16];
      f = 32'(xk) * 32'(wk);
      s = s + f[23:8];
    end
    neg = s[15];
    a = neg ? -s : s;
    if ($unsigned(a) >= 16'd1280)     begin sl = 0;  of = 216 + 40; end
    else if ($unsigned(a) >= 16'd608) begin sl = 8;  of = 216; end
    else if ($unsigned(a) >= 16'd256) begin sl = 32; of = 160; end
    else                              begin sl = 64; of = 128; end
    f = 32'(a) * 32'(sl);
    y = f[23:8] + of;
    return neg ? 16'sd256 - y : y;
  endfunction

  task automatic load_w(input logic [NI*16-1:0] wv);
    for (int k = 0; k < NI; k++) begin
      @(negedge clk); wt_we = 1; wt_sel = 3'(k); wt_val = wv[k*16 +: 16];
    end
    @(negedge clk); wt_we = 0;
  endtask

  task automatic run(input logic [NI*16-1:0] xv, input logic signed [15:0] exp, input string req);
    int lat;
    @(negedge clk); in_vec = xv; in_valid = 1; #1;
    chk(in_ack === 1'b1, "R7", int'(in_ack), 1);
    @(negedge clk); #1;
    chk(in_ack === 1'b0, "R7", int'(in_ack), 0);
    in_valid = 0; in_vec = ~xv;
    lat = 1;
    while (!out_valid && lat < 200) begin @(negedge clk); lat++; end
    chk(out_data === exp, req, int'(out_data), int'(exp));
    chk(lat == LAT, "R9", lat, LAT);
    in_valid = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(in_ack === 1'b0 && out_valid === 1'b1 && out_data === exp, "R8", int'(out_data), int'(exp));
    end
    in_valid = 0; out_ready = 1;
    @(negedge clk); out_ready = 0; #1;
    chk(out_valid === 1'b0, "R8", int'(out_valid), 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid === 1'b0, "R1", int'(out_valid), 0);
    chk(in_ack === 1'b0, "R1", int'(in_ack), 0);
    rst_n = 1;
    // R1: reset weights are zero, so the sum is zero and the sigmoid gives 0.5
    run(TX[2], 16'sd128, "R1");

    // R2 R3 R4 R5: table walk against the reference model
    for (int v = 0; v < NV; v++) begin
      load_w(TW[v]);
      run(TX[v], ref_out(TX[v], TW[v]), (v % 2 == 0) ? "R3" : "R2");
    end

    load_w({16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0100});
    run({80'h0, 16'sd0},      16'sd128, "R4");
    run({80'h0, 16'sd608},    16'sd235, "R4");
    run({80'h0, 16'sd607},    16'sd235, "R4");
    run({80'h0, 16'sd256},    16'sd192, "R4");
    run({80'h0, -16'sd256},   16'sd64,  "R5");
    run({80'h0, -16'sd100},   16'sd103, "R5");
    run({80'h0, 16'sd1280},   16'sd256, "R6");
    run({80'h0, -16'sd1280},  16'sd0,   "R6");
    run({80'h0, 16'h8000},    16'sd0,   "R6");
    // R2: only slot 5 weighted, input 5 alone drives the sum
    load_w({16'h0100, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0});
    run({16'sd300, 80'h0}, 16'sd197, "R2");
    finish_up();
  end
endmodule